// File: doc/BRIEF.md
# Stallable Programmable Delay Line

This block delays a stream of 16-bit samples by a run-time programmable number of accepted cycles. A cycle is accepted when the write enable is high and the global stall is low. In each accepted cycle the incoming sample goes into a circular register array. The sample written the same number of accepted cycles earlier is moved to the registered output, and the valid flag is raised. A fabric uses it to line up two copies of a stream that reach an operator with different latencies.

The delay is taken from a configuration input. It counts accepted cycles, not clock cycles, so idle cycles and stalled cycles do not shorten or lengthen it. The output flag stays low until the array has been filled once. A global stall freezes every register in the block, including the output. When the stall is released, the stream carries on from the exact sample where it stopped.

Top module: `sdl_delay_line`

## Requirements
- R1: In an accepted cycle (write enable high, stall low) that finds the array full and has read enable high, the output data after the next clock edge equals the sample presented in the accepted cycle exactly depth accepted cycles earlier.
- R2: The delay is the configuration value, any integer from 1 to MAX_DEPTH (default 512). It is loaded while reset is asserted and takes effect from the first accepted cycle after reset.
- R3: After reset, the first depth accepted cycles only fill the array. The valid output is low after each of them and the data output keeps its value.
- R4: Every accepted cycle after the fill period with read enable high drives valid high at the next edge, so a continuous stream gives valid high on every cycle.
- R5: While stall is high, the data and valid outputs keep their values and the data input is not stored, whatever it carries.
- R6: After a stall is released, the output sequence continues with the next sample in order, with no sample skipped or repeated.
- R7: A cycle with stall low and write enable low stores nothing and does not advance the delay. Valid goes low and the data output keeps its value.
- R8: An accepted cycle with read enable low still stores its sample and drops the oldest one. Valid goes low and the data output keeps its value.
- R9: An active-low reset is applied asynchronously and released synchronously. It clears the data output to 0, drives valid to 0 and restarts the fill period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Global stall; freezes all state when high |
| wr_en_i | input | 1 | Accept the input sample this cycle |
| rd_en_i | input | 1 | Present the evicted sample on the output this cycle |
| data_i | input | 16 | Input sample |
| depth_i | input | 10 | Delay in accepted cycles, 1 to MAX_DEPTH |
| data_o | output | 16 | Delayed sample, registered |
| valid_o | output | 1 | High when data_o was updated by the last accepted cycle |

## Verification
The delay is tried with a continuous stream at depths 1, 3, 10 and 512. The distinct values and steady cadence separate an off-by-one delay from a correct one and show a pointer that wraps at the wrong place. One stream has idle cycles scattered through it, which shows whether the delay counts accepted cycles or clock cycles. A long stall carrying changing garbage on the data input, followed by a release, tells a true freeze apart from a design that loses, repeats or stores samples across the stall. Streams with read enable dropped and a reset in the middle of a stream separate the output gating and the restart of the fill period from the main data path.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

  localparam int unsigned SDL_DATA_W    = 16;
  localparam int unsigned SDL_MAX_DEPTH = 512;

  // What one clock cycle does to the delay line
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,  // stalled: nothing moves
    ACT_IDLE  = 2'd1,  // no sample offered
    ACT_FILL  = 2'd2,  // sample stored, array not yet full
    ACT_SHIFT = 2'd3   // sample stored, oldest sample evicted
  } sdl_act_e;

endpackage

// File: rtl/sdl_rst_sync.sv
module sdl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/sdl_seq_ctrl.sv
module sdl_seq_ctrl
  import sdl_pkg::*;
#(
  parameter int unsigned MAX_DEPTH = SDL_MAX_DEPTH,
  parameter int unsigned DEPTH_W   = $clog2(MAX_DEPTH + 1),
  parameter int unsigned AW        = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall_i,
  input  logic               wr_en_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output sdl_act_e           act_o,
  output logic [AW-1:0]      ptr_o,
  output logic               full_o
);

  logic [AW-1:0]      ptr_q, ptr_d;
  logic [DEPTH_W-1:0] fill_q, fill_d;
  logic               full;
  logic               at_last;
  logic               adv_en;
  sdl_act_e           act;

  assign full    = (fill_q == depth_i);
  assign at_last = (DEPTH_W'(ptr_q) == (depth_i - DEPTH_W'(1)));

  always_comb begin
    if (stall_i) begin
      act = ACT_HOLD;
    end else if (!wr_en_i) begin
      act = ACT_IDLE;
    end else if (full) begin
      act = ACT_SHIFT;
    end else begin
      act = ACT_FILL;
    end
  end

  always_comb begin
    adv_en = (act == ACT_FILL) || (act == ACT_SHIFT);
    ptr_d  = at_last ? '0 : ptr_q + AW'(1);
    fill_d = (act == ACT_FILL) ? fill_q + DEPTH_W'(1) : fill_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      fill_q <= '0;
    end else if (adv_en) begin
      ptr_q  <= ptr_d;
      fill_q <= fill_d;
    end
  end

  assign act_o  = act;
  assign ptr_o  = ptr_q;
  assign full_o = full;

endmodule

// File: rtl/sdl_store.sv
module sdl_store #(
  parameter int unsigned ENTRIES = 512,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned AW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic hit;
    assign hit = we_i && (addr_i == AW'(g));
    always_ff @(posedge clk) begin
      if (hit) begin
        mem_q[g] <= wdata_i;
      end
    end
  end

  // Read and write share one slot: the old word leaves as the new one lands
  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/sdl_delay_line.sv
module sdl_delay_line
  import sdl_pkg::*;
#(
  parameter int unsigned DATA_W    = SDL_DATA_W,
  parameter int unsigned MAX_DEPTH = SDL_MAX_DEPTH,
  localparam int unsigned DEPTH_W  = $clog2(MAX_DEPTH + 1),
  localparam int unsigned AW       = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               valid_o
);

  logic              rst_sync_n;
  sdl_act_e          act;
  logic [AW-1:0]     ptr;
  logic              full;
  logic              store_we;
  logic [DATA_W-1:0] evict_data;

  logic [DATA_W-1:0] dout_q, dout_d;
  logic              vld_q, vld_d;
  logic              out_en;

  sdl_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sdl_seq_ctrl #(
    .MAX_DEPTH (MAX_DEPTH),
    .DEPTH_W   (DEPTH_W),
    .AW        (AW)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .stall_i (stall_i),
    .wr_en_i (wr_en_i),
    .depth_i (depth_i),
    .act_o   (act),
    .ptr_o   (ptr),
    .full_o  (full)
  );

  assign store_we = (act == ACT_FILL) || (act == ACT_SHIFT);

  sdl_store #(
    .ENTRIES (MAX_DEPTH),
    .DATA_W  (DATA_W),
    .AW      (AW)
  ) u_store (
    .clk     (clk),
    .we_i    (store_we),
    .addr_i  (ptr),
    .wdata_i (data_i),
    .rdata_o (evict_data)
  );

  // Output stage: frozen on HOLD, otherwise valid follows the action
  always_comb begin
    out_en = (act != ACT_HOLD);
    vld_d  = (act == ACT_SHIFT) && rd_en_i;
    dout_d = vld_d ? evict_data : dout_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dout_q <= '0;
      vld_q  <= 1'b0;
    end else if (out_en) begin
      dout_q <= dout_d;
      vld_q  <= vld_d;
    end
  end

  assign data_o  = dout_q;
  assign valid_o = vld_q;

endmodule

// File: rtl/sdl_delay_line_chk.sv
module sdl_delay_line_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              stall_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic              full,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o
);

  p_stall_freeze_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stall_i |=> $stable(data_o) && $stable(valid_o));

  p_idle_no_valid_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!stall_i && !wr_en_i) |=> (!valid_o && $stable(data_o)));

  p_read_mask_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!stall_i && wr_en_i && !rd_en_i) |=> (!valid_o && $stable(data_o)));

  p_steady_valid_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!stall_i && wr_en_i && rd_en_i && full) |=> valid_o);

  p_fill_quiet_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!stall_i && wr_en_i && !full) |=> (!valid_o && $stable(data_o)));

endmodule

bind sdl_delay_line sdl_delay_line_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .stall_i    (stall_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .full       (full),
  .data_o     (data_o),
  .valid_o    (valid_o)
);

// File: tb/sdl_delay_line_tb.sv
`timescale 1ns/1ps
module sdl_delay_line_tb;

  localparam int DW  = 16;
  localparam int DPW = 10;

  logic           clk;
  logic           rst_n;
  logic           stall_i;
  logic           wr_en_i;
  logic           rd_en_i;
  logic [DW-1:0]  data_i;
  logic [DPW-1:0] depth_i;
  logic [DW-1:0]  data_o;
  logic           valid_o;

  sdl_delay_line u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall_i (stall_i),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .data_i  (data_i),
    .depth_i (depth_i),
    .data_o  (data_o),
    .valid_o (valid_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model
  int            depth_m;
  logic [DW-1:0] hist [$];
  logic          exp_v;
  logic [DW-1:0] exp_d;
  int            seq_n;

  // scoreboard queues
  logic          q_v [$];
  logic [DW-1:0] q_d [$];
  string         q_req [$];

  task automatic check(input string req, input logic av, input logic [DW-1:0] ad,
                       input logic ev, input logic [DW-1:0] ed);
    n_checks++;
    if (av !== ev || (ev && ad !== ed) || (!ev && ad !== ed)) begin
      n_fail++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
               req, av, ad, ev, ed);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (q_v.size() > 0) begin
      check(q_req.pop_front(), valid_o, data_o, q_v.pop_front(), q_d.pop_front());
    end
  end

  // driver: one clock cycle, model update, expectation pushed
  task automatic cyc(input logic st, input logic wr, input logic rd,
                     input logic [DW-1:0] d, input string req);
    logic [DW-1:0] ev;
    @(negedge clk); #1;
    stall_i = st; wr_en_i = wr; rd_en_i = rd; data_i = d;
    @(posedge clk); #1;
    if (!st) begin
      if (wr) begin
        hist.push_back(d);
        if (hist.size() > depth_m) begin
          ev = hist.pop_front();
          if (rd) begin
            exp_v = 1'b1;
            exp_d = ev;
          end else begin
            exp_v = 1'b0;
          end
        end else begin
          exp_v = 1'b0;
        end
      end else begin
        exp_v = 1'b0;
      end
    end
    q_v.push_back(exp_v);
    q_d.push_back(exp_d);
    q_req.push_back(req);
  endtask

  task automatic stream(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 1'b1, 1'b1, 16'(seq_n * 37 + 5), req);
      seq_n++;
    end
  endtask

  task automatic stall_for(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, (i % 2) == 0, 1'b1, 16'hDEAD ^ 16'(i * 911), "R5");
    end
  endtask

  // R9: asynchronous reset, new depth loaded under reset (R2)
  task automatic do_reset(input int d);
    @(negedge clk); #1;
    rst_n = 1'b0; stall_i = 1'b1; wr_en_i = 1'b0; rd_en_i = 1'b0;
    depth_i = DPW'(d);
    #1;
    check("R9", valid_o, data_o, 1'b0, '0);
    hist.delete();
    depth_m = d;
    exp_v = 1'b0;
    exp_d = '0;
    @(negedge clk); #1;
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, '0, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stall_i = 1'b1; wr_en_i = 1'b0; rd_en_i = 1'b0;
    data_i = '0; depth_i = DPW'(10);
    seq_n = 0; depth_m = 10; exp_v = 1'b0; exp_d = '0;
    repeat (2) @(posedge clk);

    // depth 10: fill, steady stream, stall, resume
    do_reset(10);
    stream(10, "R3");
    stream(20, "R1");
    stream(5, "R4");
    stall_for(20);
    stream(15, "R6");
    // idle cycles do not advance the delay
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b1, 16'h5A5A, "R7");
    stream(4, "R7");
    // read enable low: sample still consumed, output gated
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, 1'b1, 1'b0, 16'(seq_n * 37 + 5), "R8");
      seq_n++;
    end
    stream(12, "R1");

    // reset in mid-stream restarts the fill period
    do_reset(1);
    stream(8, "R2");

    // depth 3 with idle gaps
    do_reset(3);
    for (int i = 0; i < 20; i++) begin
      if (i % 3 == 1) cyc(1'b0, 1'b0, 1'b1, 16'hFFFF, "R7");
      else stream(1, "R2");
    end

    // maximum depth with a stall past the wrap point
    do_reset(512);
    stream(512, "R3");
    stream(30, "R2");
    stall_for(7);
    stream(40, "R6");

    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule